// File: doc/BRIEF.md
# Forwarding Store Queue

This block sits between one execution core and a shared word memory. The core hands it stores (address and data), and the block takes each store at once, so the core never waits for the physical memory write. Queued stores are written to memory later, one per cycle, oldest first, in any cycle where the memory write port is not held busy.

The owning core issues loads through its own port. Such a load is compared against every pending store. When it matches, it is served from the queue with the data of the youngest matching store. When nothing matches, it reads memory, even if stores to other addresses are still waiting. A second load port stands for another agent. It only reads memory, so until a store drains, that agent sees the old value. An empty flag lets a test wait until every accepted store has reached memory.

The memory is a synchronous word array inside the top module. It has one write port, used for draining, and one read port per agent. Both load ports return their result exactly one cycle after the request.

Top module: `sbuf_fwd_top`

## Requirements
- R1: `st_ready` is high while fewer than DEPTH (default 8) stores are pending and low while DEPTH are pending, even in a cycle where an entry drains. A store is accepted only in a cycle with `st_valid` and `st_ready` both high.
- R2: In every cycle where at least one store is pending and `wport_busy` is low, exactly one entry drains to memory, and entries drain in acceptance order. Two stores to one address therefore leave the later data in memory.
- R3: A core load whose address equals a pending store's address returns that buffered data, and `ld_hit` is 1 in the result cycle.
- R4: When several pending stores match a core load, the data of the most recently accepted one is returned.
- R5: A core load with no matching pending store returns the memory word with `ld_hit` equal to 0, even when stores to other addresses are pending.
- R6: External loads return only the memory word. A store becomes visible to them for requests made in cycles after the cycle in which it drained.
- R7: A core load in the same cycle as the drain of its matching entry still returns that entry's data.
- R8: `ld_rvalid` and `ext_rvalid` are high exactly in the cycle after a cycle with `ld_valid` or `ext_valid` high, respectively.
- R9: `sb_empty` is 1 exactly when no store is pending.
- R10: After reset, `sb_empty` is 1, `st_ready` is 1, `ld_rvalid` is 0 and every memory word reads 0.
- R11: A store accepted in the same cycle as a core load is not visible to that load.
- R12: Addresses are word indices below 2^MEM_AW (default 64). Memory uses address bits [MEM_AW-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | AW | Core load word address |
| ld_rvalid | output | 1 | Core load result valid |
| ld_rdata | output | DW | Core load result |
| ld_hit | output | 1 | Result came from the queue |
| ext_valid | input | 1 | External agent load request |
| ext_addr | input | AW | External load word address |
| ext_rvalid | output | 1 | External load result valid |
| ext_rdata | output | DW | External load result |
| wport_busy | input | 1 | Memory write port unavailable; holds draining |
| sb_empty | output | 1 | No store pending |

## Verification
Two events collide in this block. The first is a core load that hits an entry in the same cycle that entry drains. The second is a store accepted in the same cycle as a core load to its address. Both are provoked on purpose: the queue is filled while `wport_busy` holds draining, then released while loads to the same address run each cycle. Long random stretches also use a small address set and a toggling write-port hold. A bench-side queue and memory model, updated at each edge, sets the expected value: the youngest match in the state before the edge, or else the memory word before the drain write. Hits on a draining head are reported under R7.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_BUF = 1'b1
  } ld_src_e;

  // Position of an entry counted from the oldest, on a ring of size 2**pw.
  function automatic logic [7:0] ring_age(input logic [7:0] slot,
                                          input logic [7:0] head,
                                          input int unsigned pw);
    logic [7:0] diff;
    diff = slot - head;
    return diff & ((8'd1 << pw) - 8'd1);
  endfunction

  // True when a ring entry at the given age holds a pending store.
  function automatic logic age_live(input logic [7:0] age,
                                    input logic [8:0] count);
    return {1'b0, age} < count;
  endfunction

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data,
  output logic [PW-1:0]             rd_ptr,
  output logic [CW-1:0]             count
);

  logic [PW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(g)) begin
        ent_addr[g] <= push_addr;
        ent_data[g] <= push_data;
      end
    end
  end

  assign head_addr = ent_addr[rd_ptr];
  assign head_data = ent_data[rd_ptr];

endmodule

// File: rtl/sbuf_match.sv
module sbuf_match
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]  ent_data,
  input  logic [PW-1:0]             rd_ptr,
  input  logic [CW-1:0]             count,
  input  logic [AW-1:0]             ld_addr,
  output logic                      hit,
  output logic [DW-1:0]             hit_data
);

  logic [DEPTH-1:0]         eq;
  logic [DEPTH-1:0][PW-1:0] age;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [7:0] age8;
    assign age8   = ring_age(8'(g), 8'(rd_ptr), PW);
    assign age[g] = age8[PW-1:0];
    assign eq[g]  = age_live(age8, 9'(count)) && (ent_addr[g] == ld_addr);
  end

  // The youngest match is the one with the greatest age from the head.
  always_comb begin
    logic [PW-1:0] best;
    hit      = 1'b0;
    best     = '0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eq[i] && (!hit || age[i] > best)) begin
        hit      = 1'b1;
        best     = age[i];
        hit_data = ent_data[i];
      end
    end
  end

endmodule

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
  parameter int MEM_AW = 6,
  parameter int DW     = 32,
  localparam int WORDS = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [MEM_AW-1:0] raddr0,
  output logic [DW-1:0]     rdata0,
  input  logic [MEM_AW-1:0] raddr1,
  output logic [DW-1:0]     rdata1
);

  logic [DW-1:0] mem [WORDS];

  // Reads return the contents before a write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdata0 <= '0;
      rdata1 <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata0 <= mem[raddr0];
      rdata1 <= mem[raddr1];
    end
  end

endmodule

// File: rtl/sbuf_fwd_top.sv
module sbuf_fwd_top
  import sbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int MEM_AW = 6,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_rvalid,
  output logic [DW-1:0] ld_rdata,
  output logic          ld_hit,
  input  logic          ext_valid,
  input  logic [AW-1:0] ext_addr,
  output logic          ext_rvalid,
  output logic [DW-1:0] ext_rdata,
  input  logic          wport_busy,
  output logic          sb_empty
);

  logic                     push, pop, hit_any;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data, hit_data, mem_rd0, fwd_q;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [PW-1:0]            rd_ptr;
  logic [CW-1:0]            count;
  ld_src_e                  src_q;

  assign st_ready = (count != CW'(DEPTH));
  assign sb_empty = (count == '0);
  assign push     = st_valid && st_ready;
  assign pop      = !sb_empty && !wport_busy;

  sbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .head_addr(head_addr), .head_data(head_data),
    .ent_addr(ent_addr), .ent_data(ent_data),
    .rd_ptr(rd_ptr), .count(count)
  );

  sbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ent_addr(ent_addr), .ent_data(ent_data),
    .rd_ptr(rd_ptr), .count(count), .ld_addr(ld_addr),
    .hit(hit_any), .hit_data(hit_data)
  );

  sbuf_mem #(.MEM_AW(MEM_AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(pop), .waddr(head_addr[MEM_AW-1:0]), .wdata(head_data),
    .raddr0(ld_addr[MEM_AW-1:0]), .rdata0(mem_rd0),
    .raddr1(ext_addr[MEM_AW-1:0]), .rdata1(ext_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_rvalid  <= 1'b0;
      ext_rvalid <= 1'b0;
      src_q      <= SRC_MEM;
      fwd_q      <= '0;
    end else begin
      ld_rvalid  <= ld_valid;
      ext_rvalid <= ext_valid;
      src_q      <= hit_any ? SRC_BUF : SRC_MEM;
      fwd_q      <= hit_data;
    end
  end

  assign ld_hit   = (src_q == SRC_BUF);
  assign ld_rdata = ld_hit ? fwd_q : mem_rd0;

endmodule

// File: rtl/sbuf_fwd_checker.sv
module sbuf_fwd_checker #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          st_ready,
  input logic          sb_empty,
  input logic [PW-1:0] rd_ptr,
  input logic [CW-1:0] count,
  input logic          ld_valid,
  input logic          ld_rvalid,
  input logic          ld_hit,
  input logic          hit_any
);

  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) |-> !st_ready);

  a_r1_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> count == $past(count) + CW'(1));

  a_r2_head_advances: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_ptr == $past(rd_ptr) + PW'(1));

  a_r9_fill_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb_empty) |-> $past(push));

  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> ld_rvalid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !ld_rvalid);

  a_r3_hit_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && hit_any |=> ld_hit);

  a_r5_miss_reads_mem: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !hit_any |=> !ld_hit);

endmodule

bind sbuf_fwd_top sbuf_fwd_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
  .st_ready(st_ready), .sb_empty(sb_empty), .rd_ptr(rd_ptr),
  .count(count), .ld_valid(ld_valid), .ld_rvalid(ld_rvalid),
  .ld_hit(ld_hit), .hit_any(hit_any)
);

// File: tb/sbuf_fwd_top_test.sv
`timescale 1ns/1ps
module sbuf_fwd_top_test;

  localparam int DEPTH = 8;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, ld_valid = 1'b0, ext_valid = 1'b0, wport_busy = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0, ext_addr = '0;
  logic        st_ready, ld_rvalid, ld_hit, ext_rvalid, sb_empty;
  logic [31:0] ld_rdata, ext_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] qa [DEPTH];
  logic [31:0] qd [DEPTH];
  int          qn = 0;
  logic [31:0] mm [WORDS];

  always #2.5 clk = ~clk;

  sbuf_fwd_top uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_rvalid(ld_rvalid),
    .ld_rdata(ld_rdata), .ld_hit(ld_hit),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_rvalid(ext_rvalid),
    .ext_rdata(ext_rdata), .wport_busy(wport_busy), .sb_empty(sb_empty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Youngest pending match in the model, searched before the store of this cycle.
  function automatic int youngest(input logic [31:0] a, output int nmatch);
    int idx = -1;
    nmatch = 0;
    for (int k = 0; k < qn; k++)
      if (qa[k] == a) begin idx = k; nmatch++; end
    return idx;
  endfunction

  // One clock: drive at the falling edge, update the model, check at the next falling edge.
  task automatic step(input bit stv, input logic [31:0] sta, input logic [31:0] std,
                      input bit ldv, input logic [31:0] lda,
                      input bit exv, input logic [31:0] exa, input bit busy);
    int idx, nm;
    bit exp_hit, draining, r7;
    logic [31:0] exp_ld, exp_ex;
    string tag;
    st_valid = stv; st_addr = sta; st_data = std;
    ld_valid = ldv; ld_addr = lda;
    ext_valid = exv; ext_addr = exa;
    wport_busy = busy;
    idx      = youngest(lda, nm);
    exp_hit  = (idx >= 0);
    exp_ld   = exp_hit ? qd[idx] : mm[lda[5:0]];
    exp_ex   = mm[exa[5:0]];
    draining = (qn > 0) && !busy;
    r7       = exp_hit && draining && idx == 0;
    if (draining) begin
      mm[qa[0][5:0]] = qd[0];
      for (int k = 0; k < DEPTH - 1; k++) begin qa[k] = qa[k+1]; qd[k] = qd[k+1]; end
      qn--;
    end
    if (stv && (qn + (draining ? 1 : 0)) < DEPTH) begin
      qa[qn] = sta; qd[qn] = std; qn++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(ld_rvalid == ldv, "R8 ld_rvalid", 32'(ld_rvalid), 32'(ldv));
    chk(ext_rvalid == exv, "R8 ext_rvalid", 32'(ext_rvalid), 32'(exv));
    if (ldv) begin
      tag = exp_hit ? (r7 ? "R7" : (nm > 1 ? "R4" : "R3")) : "R5";
      chk(ld_hit == exp_hit, {tag, " hit flag"}, 32'(ld_hit), 32'(exp_hit));
      chk(ld_rdata == exp_ld, {tag, " load data"}, ld_rdata, exp_ld);
    end
    if (exv) chk(ext_rdata == exp_ex, "R6 external data", ext_rdata, exp_ex);
    chk(st_ready == (qn < DEPTH), "R1 st_ready", 32'(st_ready), 32'(qn < DEPTH));
    chk(sb_empty == (qn == 0), "R9 sb_empty", 32'(sb_empty), 32'(qn == 0));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < WORDS; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(sb_empty == 1'b1, "R10 empty after reset", 32'(sb_empty), 1);
    chk(st_ready == 1'b1, "R10 ready after reset", 32'(st_ready), 1);
    chk(ld_rvalid == 1'b0, "R10 rvalid after reset", 32'(ld_rvalid), 0);
    step(0, 0, 0, 1, 32'd5, 1, 32'd17, 0);
    chk(ld_rdata == 32'd0 && ext_rdata == 32'd0, "R10 memory zero",
        ld_rdata | ext_rdata, 0);

    // R1/R4: fill to capacity with the port held, same address each time
    for (int i = 0; i < DEPTH; i++) step(1, 32'd3, 32'd100 + 32'(i), 0, 0, 0, 0, 1);
    chk(st_ready == 1'b0, "R1 full drops ready", 32'(st_ready), 0);
    step(1, 32'd3, 32'hDEAD, 1, 32'd3, 1, 32'd3, 1);
    chk(ld_rdata == 32'd107, "R4 youngest of eight", ld_rdata, 32'd107);
    chk(ext_rdata == 32'd0, "R6 stale for external agent", ext_rdata, 0);
    step(0, 0, 0, 1, 32'd9, 0, 0, 1);
    chk(ld_hit == 1'b0, "R5 miss with queue full", 32'(ld_hit), 0);
    // Release: loads to the same address while draining, last one is R7
    while (qn > 0) step(0, 0, 0, 1, 32'd3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 32'd3, 0);
    chk(ext_rdata == 32'd107, "R6 visible after drain", ext_rdata, 32'd107);

    // R2: order of two stores to one address
    step(1, 32'd30, 32'd1, 0, 0, 0, 0, 1);
    step(1, 32'd30, 32'd2, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 32'd30, 0);
    chk(ext_rdata == 32'd2, "R2 later store wins in memory", ext_rdata, 32'd2);

    // R11: store and load in one cycle
    step(1, 32'd20, 32'h55, 1, 32'd20, 0, 0, 1);
    chk(ld_hit == 1'b0 && ld_rdata == 32'd0, "R11 same-cycle store unseen",
        ld_rdata, 0);
    step(0, 0, 0, 1, 32'd20, 0, 0, 1);
    chk(ld_rdata == 32'h55, "R11 seen next cycle", ld_rdata, 32'h55);

    // R7: single entry draining while loaded
    step(0, 0, 0, 1, 32'd20, 0, 0, 0);
    chk(ld_rdata == 32'h55 && ld_hit, "R7 drain and load together", ld_rdata, 32'h55);

    // R12 and mixed traffic: random addresses in a small window
    for (int n = 0; n < 4000; n++) begin
      bit busy_r = ((n / 64) % 2 == 0) ? ($urandom % 4 != 0) : ($urandom % 5 == 0);
      step($urandom % 3 != 0, 32'($urandom % 8), $urandom,
           $urandom % 2 == 0, 32'($urandom % 10),
           $urandom % 2 == 0, 32'($urandom % 10), busy_r);
    end
    while (qn > 0) step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int a = 0; a < 10; a++) step(0, 0, 0, 1, 32'(a), 1, 32'(a), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule